// File: doc/BRIEF.md
# Interrupt Aggregation and Keyed Soft-Reset Unit

This block gathers the event sources of a serial-peripheral master into one interrupt status register and drives a single level-sensitive interrupt line toward the processor. Each event arrives from the serial core as a one-cycle pulse and latches into its own status bit. Software clears a bit by writing a one to it. A handler can therefore read the status word and write the same value back to acknowledge exactly the events it saw. A per-bit enable mask and a global gate decide whether pending status reaches the interrupt line. The line is registered, so it follows the register contents one clock later.

The same 32-bit register bus also reaches a keyed soft-reset register. A write with the correct key produces a reset pulse of fixed length. That pulse is sent to the serial core and also clears every register in this unit. Any other value written there leaves the peripheral untouched and raises a one-cycle error indication instead.

The event sources occupy status bits in this order: bit 0 master mode fault, bit 1 selected-as-slave fault, bit 2 transmit queue empty, bit 3 transmit underrun, bit 4 receive queue full, bit 5 receive overrun, bit 6 transmit queue half empty.

Top module: `irq_srst_unit`

## Requirements
- R1: After the synchronous reset, every register reads zero and `irq`, `core_rst` and `key_err` are all low.
- R2: An event pulse on `evt[i]` sets status bit i, which stays set and reads back at offset 0x20 in bits 6:0. Bit i maps to the source order given above.
- R3: A write to offset 0x20 clears exactly the status bits written as one and leaves all other bits unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when, one clock earlier, the global enable was set and at least one status bit had its enable bit set.
- R6: The global enable is bit 31 of offset 0x1C. Only that bit is stored, and it reads back in bit 31 with all other bits zero.
- R7: The per-bit enable register at offset 0x28 stores bits 6:0 of the written value and reads back zero above them.
- R8: Writing exactly 0x0000000A to offset 0x40 drives `core_rst` high for 16 consecutive clocks, starting at the clock edge that takes the write. Every register of the unit is then zero and `irq` is low.
- R9: Writing any other value to offset 0x40 makes `key_err` high for one clock, starting at the edge that takes the write. It does not assert `core_rst` and does not change any register.
- R10: While `core_rst` is high, bus writes and event pulses are ignored. This includes a second correct key, so the reset pulse is not extended.
- R11: Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr`, combinational |
| evt | input | 7 | One-cycle event pulses from the serial core |
| irq | output | 1 | Registered level interrupt |
| core_rst | output | 1 | Soft-reset pulse for the serial core and this unit |
| key_err | output | 1 | One-cycle flag for a soft-reset write with the wrong key |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe with a stable address and data during that cycle, and that each `evt` bit is a pulse sampled only at rising edges. They do not assume that events and writes are kept apart: collisions between an event and a clear are legal and are checked. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It sweeps all 128 status patterns against all 128 enable masks, and it issues writes and events on purpose during the reset pulse to confirm that they are discarded.

// File: rtl/irq_srst_pkg.sv
package irq_srst_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int GIE_BIT = 31;

    localparam logic [ADDR_W-1:0] ADR_GLOBAL = 8'h1C;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 8'h28;
    localparam logic [ADDR_W-1:0] ADR_SRESET = 8'h40;

    typedef struct packed {
        logic global_ld;
        logic status_clr;
        logic enable_ld;
        logic sreset;
    } wr_sel_t;

    function automatic logic pending_any(input logic gate,
                                         input logic [DATA_W-1:0] st,
                                         input logic [DATA_W-1:0] en);
        return gate & (|(st & en));
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_srst_pkg::*;
#(
    parameter int NUM_EVT = 7
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 hold,
    input  logic [NUM_EVT-1:0]   status_q,
    input  logic [NUM_EVT-1:0]   enable_q,
    input  logic                 gie_q,
    output wr_sel_t              wsel,
    output logic [DATA_W-1:0]    rdata
);

    always_comb begin
        wsel = '0;
        if (bus_wr && !hold) begin
            case (bus_addr)
                ADR_GLOBAL: wsel.global_ld  = 1'b1;
                ADR_STATUS: wsel.status_clr = 1'b1;
                ADR_ENABLE: wsel.enable_ld  = 1'b1;
                ADR_SRESET: wsel.sreset     = 1'b1;
                default:    wsel            = '0;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (bus_addr)
            ADR_GLOBAL: rdata[GIE_BIT]       = gie_q;
            ADR_STATUS: rdata[NUM_EVT-1:0]   = status_q;
            ADR_ENABLE: rdata[NUM_EVT-1:0]   = enable_q;
            default:    rdata                = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_srst_pkg::*;
#(
    parameter int NUM_EVT = 7
) (
    input  logic                 clk,
    input  logic                 clr,
    input  wr_sel_t              wsel,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_EVT-1:0]   evt,
    output logic [NUM_EVT-1:0]   status_q,
    output logic [NUM_EVT-1:0]   enable_q,
    output logic                 gie_q,
    output logic                 irq_q
);

    logic [NUM_EVT-1:0] clr_mask;
    logic [NUM_EVT-1:0] status_d;

    assign clr_mask = wsel.status_clr ? wdata[NUM_EVT-1:0] : '0;

    // Per-bit update: a pulse in the same cycle as a clear keeps the bit set.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        assign status_d[i] = evt[i] | (status_q[i] & ~clr_mask[i]);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            status_q <= '0;
            enable_q <= '0;
            gie_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            if (wsel.enable_ld) enable_q <= wdata[NUM_EVT-1:0];
            if (wsel.global_ld) gie_q    <= wdata[GIE_BIT];
            irq_q <= pending_any(gie_q, DATA_W'(status_q), DATA_W'(enable_q));
        end
    end

endmodule

// File: rtl/irq_srst_seq.sv
module irq_srst_seq
    import irq_srst_pkg::*;
#(
    parameter int                RST_HOLD = 16,
    parameter logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sreset_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              key_hit,
    output logic              core_rst,
    output logic              key_err
);

    localparam int CNT_W = $clog2(RST_HOLD + 1);

    logic [CNT_W-1:0] hold_cnt;

    assign key_hit  = sreset_wr && (wdata == RST_KEY);
    assign core_rst = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            key_err  <= 1'b0;
        end else begin
            key_err <= sreset_wr && !key_hit;
            if (key_hit)
                hold_cnt <= CNT_W'(RST_HOLD);
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/irq_srst_unit.sv
module irq_srst_unit
    import irq_srst_pkg::*;
#(
    parameter int                NUM_EVT  = 7,
    parameter int                RST_HOLD = 16,
    parameter logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic               irq,
    output logic               core_rst,
    output logic               key_err
);

    wr_sel_t            wsel;
    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] enable_q;
    logic               gie_q;
    logic               key_hit;
    logic               bank_clr;

    assign bank_clr = rst | core_rst | key_hit;

    irq_bus_decode #(.NUM_EVT(NUM_EVT)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .hold     (core_rst),
        .status_q (status_q),
        .enable_q (enable_q),
        .gie_q    (gie_q),
        .wsel     (wsel),
        .rdata    (bus_rdata)
    );

    irq_status_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk      (clk),
        .clr      (bank_clr),
        .wsel     (wsel),
        .wdata    (bus_wdata),
        .evt      (evt),
        .status_q (status_q),
        .enable_q (enable_q),
        .gie_q    (gie_q),
        .irq_q    (irq)
    );

    irq_srst_seq #(.RST_HOLD(RST_HOLD), .RST_KEY(RST_KEY)) u_srst (
        .clk       (clk),
        .rst       (rst),
        .sreset_wr (wsel.sreset),
        .wdata     (bus_wdata),
        .key_hit   (key_hit),
        .core_rst  (core_rst),
        .key_err   (key_err)
    );

endmodule

// File: rtl/irq_srst_checker.sv
module irq_srst_checker
    import irq_srst_pkg::*;
#(
    parameter int                NUM_EVT  = 7,
    parameter int                RST_HOLD = 16,
    parameter logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_EVT-1:0] evt,
    input logic               irq,
    input logic               core_rst,
    input logic               key_err,
    input logic [NUM_EVT-1:0] status_q,
    input logic               gie_q
);

    localparam int HC_W = $clog2(RST_HOLD + 2);

    logic [HC_W-1:0] high_len;
    logic            good_key_wr;
    logic            status_wr;

    assign good_key_wr = bus_wr && !core_rst && (bus_addr == ADR_SRESET)
                         && (bus_wdata == RST_KEY);
    assign status_wr   = bus_wr && !core_rst && (bus_addr == ADR_STATUS);

    always_ff @(posedge clk) begin
        if (rst)           high_len <= '0;
        else if (core_rst) high_len <= high_len + 1'b1;
        else               high_len <= '0;
    end

    // R2 and R4: a pulse always leaves its bit set, even against a clear
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        ((|evt) && !core_rst && !good_key_wr)
        |=> ((status_q & $past(evt)) == $past(evt)));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (status_wr && (evt == '0))
        |=> ((status_q & $past(bus_wdata[NUM_EVT-1:0])) == '0));

    a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(gie_q));

    a_r8_hold_max: assert property (@(posedge clk) disable iff (rst)
        high_len <= HC_W'(RST_HOLD));

    a_r8_hold_len: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (high_len == HC_W'(RST_HOLD)));

    a_r9_bad_key: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !core_rst && (bus_addr == ADR_SRESET) && (bus_wdata != RST_KEY))
        |=> (key_err && !core_rst));

endmodule

bind irq_srst_unit irq_srst_checker #(
    .NUM_EVT(NUM_EVT), .RST_HOLD(RST_HOLD), .RST_KEY(RST_KEY)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (evt),
    .irq       (irq),
    .core_rst  (core_rst),
    .key_err   (key_err),
    .status_q  (status_q),
    .gie_q     (gie_q)
);

// File: tb/test_irq_srst_unit.sv
module test_irq_srst_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 7;
    localparam int HOLD       = 16;
    localparam int CYC_LIMIT  = 190000;

    localparam logic [7:0] A_GLB = 8'h1C;
    localparam logic [7:0] A_STS = 8'h20;
    localparam logic [7:0] A_ENA = 8'h28;
    localparam logic [7:0] A_RST = 8'h40;
    localparam logic [7:0] A_BAD = 8'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NE-1:0] evt = '0;
    logic        irq, core_rst, key_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int hold_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_srst_unit i_irq_srst_unit (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt),
        .irq(irq), .core_rst(core_rst), .key_err(key_err)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (core_rst) hold_seen <= hold_seen + 1;

    always @(negedge clk) begin
        if (cyc > CYC_LIMIT && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, CYC_LIMIT);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NE-1:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(A_GLB, v); chk("R1 global", v, 0);
        rd(A_STS, v); chk("R1 status", v, 0);
        rd(A_ENA, v); chk("R1 enable", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 core_rst", {31'b0, core_rst}, 0);
        chk("R1 key_err", {31'b0, key_err}, 0);

        // R2, R5, R7: every status pattern against every enable mask
        wr(A_GLB, 32'h8000_0000);
        for (int s = 0; s < 128; s++) begin
            wr(A_STS, 32'h7F);
            pulse(NE'(s));
            rd(A_STS, v); chk("R2 status latch", v, 32'(s));
            for (int e = 0; e < 128; e++) begin
                wr(A_ENA, 32'(e));
                @(negedge clk);
                chk("R5 irq level", {31'b0, irq}, {31'b0, |(s[6:0] & e[6:0])});
                if (s == 0) begin
                    rd(A_ENA, v); chk("R7 enable readback", v, 32'(e));
                end
            end
        end

        // R6: global gate at bit 31 only
        wr(A_ENA, 32'h7F);
        pulse(7'h7F);
        wr(A_GLB, 32'h0);
        @(negedge clk);
        chk("R6 irq gated off", {31'b0, irq}, 0);
        wr(A_GLB, 32'h7FFF_FFFF);
        @(negedge clk);
        rd(A_GLB, v); chk("R6 low bits dropped", v, 0);
        chk("R6 irq still off", {31'b0, irq}, 0);
        wr(A_GLB, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(A_GLB, v); chk("R6 gate readback", v, 32'h8000_0000);
        chk("R6 irq on", {31'b0, irq}, 1);

        // R7: upper enable bits ignored
        wr(A_ENA, 32'hFFFF_FFFF);
        rd(A_ENA, v); chk("R7 upper bits", v, 32'h7F);

        // R3: partial clear, then write-back of the read value
        rd(A_STS, v); chk("R3 start", v, 32'h7F);
        wr(A_STS, 32'h15);
        rd(A_STS, v); chk("R3 partial clear", v, 32'h6A);
        wr(A_STS, v);
        rd(A_STS, v); chk("R3 write back", v, 0);

        // R4: pulse colliding with a clear
        pulse(7'h7F);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h7F; evt = 7'h09;
        @(negedge clk);
        bus_wr = 1'b0; evt = '0;
        rd(A_STS, v); chk("R4 event wins", v, 32'h09);

        // R11: unmapped offset
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_BAD, v); chk("R11 unmapped read", v, 0);
        rd(A_STS, v); chk("R11 status kept", v, 32'h09);
        rd(A_ENA, v); chk("R11 enable kept", v, 32'h7F);

        // R9: wrong keys
        wr(A_ENA, 32'h33);
        wr(A_RST, 32'h0B);
        chk("R9 key_err high", {31'b0, key_err}, 1);
        chk("R9 no reset", {31'b0, core_rst}, 0);
        @(negedge clk);
        chk("R9 key_err one cycle", {31'b0, key_err}, 0);
        wr(A_RST, 32'h0000_010A);
        chk("R9 upper bits wrong", {31'b0, key_err}, 1);
        rd(A_ENA, v); chk("R9 enable kept", v, 32'h33);
        rd(A_STS, v); chk("R9 status kept", v, 32'h09);

        // R8: correct key
        wr(A_ENA, 32'h7F);
        @(negedge clk);
        chk("R8 irq before", {31'b0, irq}, 1);
        hold_seen = 0;
        wr(A_RST, 32'h0A);
        chk("R8 pulse starts", {31'b0, core_rst}, 1);
        chk("R8 no key_err", {31'b0, key_err}, 0);
        repeat (HOLD + 4) @(negedge clk);
        chk("R8 pulse length", 32'(hold_seen), HOLD);
        rd(A_GLB, v); chk("R8 global cleared", v, 0);
        rd(A_STS, v); chk("R8 status cleared", v, 0);
        rd(A_ENA, v); chk("R8 enable cleared", v, 0);
        chk("R8 irq low", {31'b0, irq}, 0);

        // R10: activity during the pulse is dropped
        hold_seen = 0;
        wr(A_RST, 32'h0A);
        wr(A_ENA, 32'h7F);
        wr(A_GLB, 32'h8000_0000);
        pulse(7'h7F);
        wr(A_RST, 32'h0A);
        repeat (HOLD + 4) @(negedge clk);
        chk("R10 not extended", 32'(hold_seen), HOLD);
        rd(A_ENA, v); chk("R10 enable ignored", v, 0);
        rd(A_GLB, v); chk("R10 global ignored", v, 0);
        rd(A_STS, v); chk("R10 event ignored", v, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule